// File: doc/BRIEF.md
# Four-Core Snooping Line-State Controller

This block holds the coherence state of a small set of cache lines for four private caches that share one snooping bus. Each cache keeps one data word and a four-valued state per line: Modified, Exclusive, Shared or Invalid. A core asks for a read, a write or an eviction of one line and holds the request until the block marks it complete.

Reads and writes that the local state already allows finish in the same cycle without touching the bus. Requests that need other caches go to a round-robin arbiter. The arbiter grants one bus transaction per cycle, and that transaction is resolved within the same cycle:

- every other cache snoops the transaction;
- the other caches report whether they hold a copy and whether that copy is dirty;
- a holder supplies its word directly to the requester;
- a dirty holder updates the line's backing memory word during the same read.

Evicting a dirty line writes its word back to memory and raises a dedicated strobe. A local hit on a line that the current bus transaction targets waits one cycle, so that a snoop and a local state change never land on the same line at the same edge.

Top module: `mesi_snoop_ctrl`

## Requirements

- R1: After reset every line of every core is Invalid and every memory word is zero. The state code is 00 for Invalid, 01 for Shared, 10 for Exclusive and 11 for Modified. Core c, line l is reported on `line_state` bits [(c*NLINE+l)*2 +: 2].
- R2: A read (op 00) to an Invalid line issues bus command 01 (read). When no other core holds the line, `bus_shared` stays low and the line fills from memory into Exclusive.
- R3: A snooped read that finds clean copies raises `bus_shared` and keeps `bus_dirty` low. Exclusive holders drop to Shared, and the requester installs the line as Shared with the supplied word.
- R4: A snooped read that finds a Modified copy raises `bus_dirty`. The holder supplies its word to the requester, the same word is written to memory, and both caches end in Shared.
- R5: A write (op 01) to an Exclusive line completes with no bus transaction and moves the line to Modified.
- R6: A write to a Shared line issues bus command 11 (upgrade). Every other copy becomes Invalid and the writer ends in Modified.
- R7: A write to an Invalid line issues bus command 10 (read for ownership). Every other copy becomes Invalid and the writer ends in Modified holding the written word.
- R8: Evicting (op 10) a Modified line raises `bus_wb` with bus command 00, stores the word to memory and leaves the line Invalid. Evicting a Shared or Exclusive line is done locally with no strobe.
- R9: At most one bus transaction takes place per cycle. Grants rotate round-robin, so when all four cores need the bus at once, they complete in four distinct consecutive cycles.
- R10: A read of a line in M, E or S, and a write of a line in M or E, complete in the cycle they are presented, with no bus transaction for that core.
- R11: A local hit on the line targeted by another core's bus transaction in the same cycle is held back one cycle. It then proceeds from the state that the snoop left behind.
- R12: On every cycle, for each line, at most one core holds it in M or E, and when one does, all other cores hold it Invalid.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCORE | Per-core request held until done |
| req_op | input | 2*NCORE | Per-core op: 00 read, 01 write, 10 evict |
| req_line | input | NCORE*LW | Per-core line index |
| req_wdata | input | NCORE*DW | Per-core write word |
| req_done | output | NCORE | Request completes at the coming edge |
| rsp_data | output | NCORE*DW | Read word for each core |
| bus_cmd | output | 2 | 00 idle, 01 read, 10 read for ownership, 11 upgrade |
| bus_wb | output | 1 | Dirty eviction writeback strobe |
| bus_line | output | LW | Line addressed by the bus transaction |
| bus_owner | output | CW | Core granted the bus |
| bus_shared | output | 1 | Some other core holds a copy |
| bus_dirty | output | 1 | Some other core holds a Modified copy |
| line_state | output | NCORE*NLINE*2 | All per-core line states, packed |

## Verification

The case that needs care is a local hit by one core landing in the same cycle as a snooped bus transaction from another core on the same line. The test sets this up with a core that holds a line Exclusive: in one cycle it presents a write to that line while a second core presents a read miss to it. The result is judged at the ports. The reader must receive the pre-write word. The writer must complete exactly one cycle later through an upgrade command. The line must end Modified in the writer and Invalid in the reader.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mstate_e;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_RD   = 2'b01,
        CMD_RDX  = 2'b10,
        CMD_UPGR = 2'b11
    } bcmd_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_EVICT = 2'b10,
        OP_NONE  = 2'b11
    } cop_e;

    // Bus command a request needs given the local state (idle if none)
    function automatic bcmd_e miss_cmd(cop_e op, mstate_e s);
        if (op == OP_READ && s == ST_I)  return CMD_RD;
        if (op == OP_WRITE && s == ST_I) return CMD_RDX;
        if (op == OP_WRITE && s == ST_S) return CMD_UPGR;
        return CMD_IDLE;
    endfunction

    function automatic logic needs_wb(cop_e op, mstate_e s);
        return (op == OP_EVICT) && (s == ST_M);
    endfunction

endpackage

// File: rtl/mesi_rr_arb.sv
module mesi_rr_arb #(
    parameter int N = 4,
    localparam int CW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [CW-1:0] gnt_id,
    output logic          any
);
    logic [CW-1:0] ptr_q;
    int idx;

    always_comb begin
        gnt    = '0;
        gnt_id = '0;
        any    = 1'b0;
        idx    = 0;
        for (int i = 0; i < N; i++) begin
            idx = (int'(ptr_q) + i) % N;
            if (!any && req[idx]) begin
                any      = 1'b1;
                gnt[idx] = 1'b1;
                gnt_id   = CW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (any)
            ptr_q <= (gnt_id == CW'(N - 1)) ? '0 : gnt_id + 1'b1;
    end
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp import mesi_pkg::*; #(
    parameter int N  = 4,
    parameter int DW = 8,
    localparam int CW = $clog2(N)
) (
    input  mstate_e         st_line  [N],
    input  logic [DW-1:0]   dat_line [N],
    input  logic [CW-1:0]   self_id,
    output logic            shared,
    output logic            dirty,
    output logic [DW-1:0]   sup_data
);
    always_comb begin
        shared   = 1'b0;
        dirty    = 1'b0;
        sup_data = '0;
        for (int i = 0; i < N; i++) begin
            if (CW'(i) != self_id && st_line[i] != ST_I) begin
                shared = 1'b1;
                if (!dirty) sup_data = dat_line[i];
                if (st_line[i] == ST_M) begin
                    dirty    = 1'b1;
                    sup_data = dat_line[i];
                end
            end
        end
    end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl import mesi_pkg::*; #(
    parameter int NCORE = 4,
    parameter int NLINE = 4,
    parameter int DW    = 8,
    localparam int LW   = $clog2(NLINE),
    localparam int CW   = $clog2(NCORE)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCORE-1:0]         req_valid,
    input  logic [2*NCORE-1:0]       req_op,
    input  logic [NCORE*LW-1:0]      req_line,
    input  logic [NCORE*DW-1:0]      req_wdata,
    output logic [NCORE-1:0]         req_done,
    output logic [NCORE*DW-1:0]      rsp_data,
    output logic [1:0]               bus_cmd,
    output logic                     bus_wb,
    output logic [LW-1:0]            bus_line,
    output logic [CW-1:0]            bus_owner,
    output logic                     bus_shared,
    output logic                     bus_dirty,
    output logic [NCORE*NLINE*2-1:0] line_state
);
    mstate_e       st_q  [NCORE][NLINE];
    logic [DW-1:0] dat_q [NCORE][NLINE];
    logic [DW-1:0] mem_q [NLINE];

    cop_e          op  [NCORE];
    logic [LW-1:0] ln  [NCORE];
    logic [DW-1:0] wd  [NCORE];
    mstate_e       cur [NCORE];
    logic [NCORE-1:0] need_bus, local_ok, blocked;

    // Request decode and local classification
    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            op[c]       = cop_e'(req_op[2*c +: 2]);
            ln[c]       = req_line[c*LW +: LW];
            wd[c]       = req_wdata[c*DW +: DW];
            cur[c]      = st_q[c][ln[c]];
            need_bus[c] = req_valid[c] &&
                          (miss_cmd(op[c], cur[c]) != CMD_IDLE || needs_wb(op[c], cur[c]));
            local_ok[c] = req_valid[c] && !need_bus[c];
        end
    end

    logic [NCORE-1:0] gnt;
    logic [CW-1:0]    gnt_id;
    logic             any_gnt;

    mesi_rr_arb #(.N(NCORE)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .req    (need_bus),
        .gnt    (gnt),
        .gnt_id (gnt_id),
        .any    (any_gnt)
    );

    bcmd_e         g_cmd;
    logic          g_wb;
    logic [LW-1:0] g_line;
    mstate_e       snp_st  [NCORE];
    logic [DW-1:0] snp_dat [NCORE];
    logic          sh, dt;
    logic [DW-1:0] sup, fill;

    always_comb begin
        g_line = ln[gnt_id];
        g_cmd  = any_gnt ? miss_cmd(op[gnt_id], cur[gnt_id]) : CMD_IDLE;
        g_wb   = any_gnt && needs_wb(op[gnt_id], cur[gnt_id]);
        for (int i = 0; i < NCORE; i++) begin
            snp_st[i]  = st_q[i][g_line];
            snp_dat[i] = dat_q[i][g_line];
        end
    end

    mesi_snoop_resp #(.N(NCORE), .DW(DW)) u_snp (
        .st_line  (snp_st),
        .dat_line (snp_dat),
        .self_id  (gnt_id),
        .shared   (sh),
        .dirty    (dt),
        .sup_data (sup)
    );

    assign fill = sh ? sup : mem_q[g_line];

    // Completion, read data and bus observation
    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            blocked[c] = any_gnt && (gnt_id != CW'(c)) && (ln[c] == g_line);
            req_done[c] = (local_ok[c] && !blocked[c]) || gnt[c];
            rsp_data[c*DW +: DW] = (gnt[c] && g_cmd == CMD_RD) ? fill : dat_q[c][ln[c]];
            for (int l = 0; l < NLINE; l++)
                line_state[(c*NLINE + l)*2 +: 2] = st_q[c][l];
        end
        bus_cmd    = g_cmd;
        bus_wb     = g_wb;
        bus_line   = g_line;
        bus_owner  = gnt_id;
        bus_shared = (g_cmd != CMD_IDLE) && sh;
        bus_dirty  = (g_cmd != CMD_IDLE) && dt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCORE; c++)
                for (int l = 0; l < NLINE; l++) begin
                    st_q[c][l]  <= ST_I;
                    dat_q[c][l] <= '0;
                end
            for (int l = 0; l < NLINE; l++) mem_q[l] <= '0;
        end else begin
            for (int c = 0; c < NCORE; c++) begin
                if (local_ok[c] && !blocked[c]) begin
                    if (op[c] == OP_WRITE) begin
                        st_q[c][ln[c]]  <= ST_M;
                        dat_q[c][ln[c]] <= wd[c];
                    end else if (op[c] == OP_EVICT) begin
                        st_q[c][ln[c]] <= ST_I;
                    end
                end
            end
            if (any_gnt) begin
                unique case (g_cmd)
                    CMD_RD: begin
                        for (int i = 0; i < NCORE; i++)
                            if (CW'(i) != gnt_id &&
                                (st_q[i][g_line] == ST_M || st_q[i][g_line] == ST_E))
                                st_q[i][g_line] <= ST_S;
                        st_q[gnt_id][g_line]  <= sh ? ST_S : ST_E;
                        dat_q[gnt_id][g_line] <= fill;
                        if (dt) mem_q[g_line] <= sup;
                    end
                    CMD_RDX, CMD_UPGR: begin
                        for (int i = 0; i < NCORE; i++)
                            if (CW'(i) != gnt_id) st_q[i][g_line] <= ST_I;
                        st_q[gnt_id][g_line]  <= ST_M;
                        dat_q[gnt_id][g_line] <= wd[gnt_id];
                    end
                    default: begin
                        if (g_wb) begin
                            mem_q[g_line]        <= dat_q[gnt_id][g_line];
                            st_q[gnt_id][g_line] <= ST_I;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
    parameter int NCORE = 4,
    parameter int NLINE = 4,
    parameter int DW    = 8,
    localparam int LW   = $clog2(NLINE),
    localparam int CW   = $clog2(NCORE),
    localparam int WAITW = $clog2(4*NCORE) + 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NCORE-1:0]         req_valid,
    input logic [2*NCORE-1:0]       req_op,
    input logic [NCORE*LW-1:0]      req_line,
    input logic [NCORE-1:0]         req_done,
    input logic [1:0]               bus_cmd,
    input logic                     bus_wb,
    input logic [LW-1:0]            bus_line,
    input logic [CW-1:0]            bus_owner,
    input logic                     bus_shared,
    input logic                     bus_dirty,
    input logic [NCORE*NLINE*2-1:0] line_state
);
    function automatic logic [1:0] st_of(input logic [NCORE*NLINE*2-1:0] v,
                                          input int c, input int l);
        return v[(c*NLINE + l)*2 +: 2];
    endfunction

    function automatic int copies(input logic [NCORE*NLINE*2-1:0] v, input int l);
        int n = 0;
        for (int c = 0; c < NCORE; c++) if (st_of(v, c, l) != 2'b00) n++;
        return n;
    endfunction

    logic inv_ok;
    always_comb begin
        inv_ok = 1'b1;
        for (int l = 0; l < NLINE; l++) begin
            int own;
            own = 0;
            for (int c = 0; c < NCORE; c++)
                if (st_of(line_state, c, l) == 2'b11 || st_of(line_state, c, l) == 2'b10) own++;
            if (own > 1 || (own == 1 && copies(line_state, l) != 1)) inv_ok = 1'b0;
        end
    end

    // R12
    swmr_chk: assert property (@(posedge clk) disable iff (rst) inv_ok);

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (line_state == '0));

    // R2
    excl_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 2'b01 && !bus_shared) |=>
            st_of(line_state, int'($past(bus_owner)), int'($past(bus_line))) == 2'b10);

    // R4
    dirty_share_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 2'b01 && bus_dirty) |=>
            st_of(line_state, int'($past(bus_owner)), int'($past(bus_line))) == 2'b01);

    // R6
    own_inval_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 2'b10 || bus_cmd == 2'b11) |=>
            (copies(line_state, int'($past(bus_line))) == 1 &&
             st_of(line_state, int'($past(bus_owner)), int'($past(bus_line))) == 2'b11));

    // R9
    one_txn_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd != 2'b00 || bus_wb) |->
            (req_valid[bus_owner] && req_done[bus_owner] && !(bus_wb && bus_cmd != 2'b00)));

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        logic [WAITW-1:0] wait_q;
        always_ff @(posedge clk) begin
            if (rst || !req_valid[c] || req_done[c]) wait_q <= '0;
            else wait_q <= wait_q + 1'b1;
        end

        // R9
        no_starve_chk: assert property (@(posedge clk) disable iff (rst)
            wait_q < WAITW'(4*NCORE));

        // R5
        silent_wr_chk: assert property (@(posedge clk) disable iff (rst)
            (req_valid[c] && req_done[c] && req_op[2*c +: 2] == 2'b01 &&
             st_of(line_state, c, int'(req_line[c*LW +: LW])) == 2'b10) |=>
                st_of(line_state, c, int'($past(req_line[c*LW +: LW]))) == 2'b11);
    end
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.NCORE(NCORE), .NLINE(NLINE), .DW(DW)) u_chk (.*);

// File: tb/sim_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_snoop_ctrl;
    localparam int NC = 4;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  req_valid = '0;
    logic [7:0]  req_op    = '0;
    logic [7:0]  req_line  = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_done;
    logic [31:0] rsp_data;
    logic [1:0]  bus_cmd;
    logic        bus_wb;
    logic [1:0]  bus_line;
    logic [1:0]  bus_owner;
    logic        bus_shared;
    logic        bus_dirty;
    logic [31:0] line_state;

    mesi_snoop_ctrl #(.NCORE(NC), .NLINE(NL), .DW(8)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_line(req_line), .req_wdata(req_wdata), .req_done(req_done),
        .rsp_data(rsp_data), .bus_cmd(bus_cmd), .bus_wb(bus_wb),
        .bus_line(bus_line), .bus_owner(bus_owner), .bus_shared(bus_shared),
        .bus_dirty(bus_dirty), .line_state(line_state)
    );

    always #2 clk = ~clk;

    typedef struct {
        int         core;
        logic [7:0] data;
        bit         chk;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    int nchk = 0, nfail = 0, cyc = 0;
    bit ended = 0;
    logic [1:0] last_cmd [NC];
    logic       last_wb [NC], last_sh [NC], last_dt [NC];
    int         start_cyc [NC], done_cyc [NC];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int st(input int c, input int l);
        return int'(line_state[(c*NL + l)*2 +: 2]);
    endfunction

    // Driver: pushes the expected response, holds the request until done
    task automatic issue(input int c, input logic [1:0] op, input int l,
                         input logic [7:0] wd, input bit chk_d,
                         input logic [7:0] exp_d, input string tag);
        exp_q.push_back('{c, exp_d, chk_d, tag});
        req_op[2*c +: 2]    = op;
        req_line[2*c +: 2]  = l[1:0];
        req_wdata[8*c +: 8] = wd;
        req_valid[c]        = 1'b1;
        start_cyc[c]        = cyc;
        do begin
            @(negedge clk); #0.5;
        end while (!req_done[c]);
        done_cyc[c] = cyc;
        last_cmd[c] = (bus_owner == 2'(c)) ? bus_cmd : 2'b00;
        last_wb[c]  = (bus_owner == 2'(c)) && bus_wb;
        last_sh[c]  = (bus_owner == 2'(c)) && bus_shared;
        last_dt[c]  = (bus_owner == 2'(c)) && bus_dirty;
        @(posedge clk); #0.5;
        req_valid[c] = 1'b0;
    endtask

    // Monitor: compares completions against the scoreboard
    initial forever begin
        @(negedge clk); #0.5;
        if (!rst) begin
            for (int c = 0; c < NC; c++) begin
                if (req_valid[c] && req_done[c]) begin
                    int k;
                    k = -1;
                    for (int j = 0; j < exp_q.size(); j++)
                        if (k < 0 && exp_q[j].core == c) k = j;
                    if (k < 0) chk(0, "R10 unexpected completion", c, -1);
                    else begin
                        if (exp_q[k].chk)
                            chk(rsp_data[8*c +: 8] == exp_q[k].data, exp_q[k].tag,
                                rsp_data[8*c +: 8], exp_q[k].data);
                        exp_q.delete(k);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst = 1'b0;
        @(negedge clk); #0.5;
        chk(line_state == '0, "R1 all lines invalid", line_state, 0);
        chk(req_done == '0, "R1 no completion", req_done, 0);
        chk(bus_cmd == 2'b00 && !bus_wb, "R1 bus idle", bus_cmd, 0);
        @(posedge clk); #0.5;

        // R2 cold read fills Exclusive
        issue(0, 2'b00, 1, 8'h00, 1, 8'h00, "R2 cold read data");
        chk(last_cmd[0] == 2'b01, "R2 read command", last_cmd[0], 1);
        chk(!last_sh[0], "R2 shared low", last_sh[0], 0);
        chk(st(0, 1) == 2, "R2 Exclusive", st(0, 1), 2);

        // R5 silent write
        issue(0, 2'b01, 1, 8'hA5, 0, 8'h00, "R5 write");
        chk(last_cmd[0] == 2'b00 && !last_wb[0], "R5 no bus", last_cmd[0], 0);
        chk(st(0, 1) == 3, "R5 Modified", st(0, 1), 3);
        chk(done_cyc[0] == start_cyc[0], "R10 write hit latency",
            done_cyc[0] - start_cyc[0], 0);

        // R4 read from a dirty owner
        issue(1, 2'b00, 1, 8'h00, 1, 8'hA5, "R4 dirty supply data");
        chk(last_dt[1], "R4 dirty flag", last_dt[1], 1);
        chk(st(0, 1) == 1 && st(1, 1) == 1, "R4 both Shared", st(0, 1), 1);

        // R8 silent evictions of clean copies, then memory holds written-back word
        issue(0, 2'b10, 1, 8'h00, 0, 8'h00, "R8 evict S");
        issue(1, 2'b10, 1, 8'h00, 0, 8'h00, "R8 evict S");
        chk(!last_wb[0] && !last_wb[1], "R8 clean evict no strobe", last_wb[0], 0);
        chk(st(0, 1) == 0 && st(1, 1) == 0, "R8 Invalid", st(1, 1), 0);
        issue(2, 2'b00, 1, 8'h00, 1, 8'hA5, "R4 memory updated on dirty read");
        chk(st(2, 1) == 2, "R2 refill Exclusive", st(2, 1), 2);

        // R7 write miss
        issue(3, 2'b01, 1, 8'h3C, 0, 8'h00, "R7 write miss");
        chk(last_cmd[3] == 2'b10, "R7 ownership command", last_cmd[3], 2);
        chk(st(2, 1) == 0 && st(3, 1) == 3, "R7 states", st(2, 1), 0);

        // R3 clean sharing
        issue(2, 2'b00, 0, 8'h00, 1, 8'h00, "R2 read line0");
        issue(3, 2'b00, 0, 8'h00, 1, 8'h00, "R3 shared read data");
        chk(last_sh[3] && !last_dt[3], "R3 shared not dirty", {last_sh[3], last_dt[3]}, 2);
        chk(st(2, 0) == 1 && st(3, 0) == 1, "R3 both Shared", st(2, 0), 1);

        // R6 upgrade
        issue(2, 2'b00, 1, 8'h00, 1, 8'h3C, "R4 dirty supply 3C");
        issue(2, 2'b01, 1, 8'h77, 0, 8'h00, "R6 upgrade");
        chk(last_cmd[2] == 2'b11, "R6 upgrade command", last_cmd[2], 3);
        chk(st(3, 1) == 0 && st(2, 1) == 3, "R6 states", st(3, 1), 0);

        // R8 dirty eviction
        issue(2, 2'b10, 1, 8'h00, 0, 8'h00, "R8 evict M");
        chk(last_wb[2] && last_cmd[2] == 2'b00, "R8 writeback strobe", last_wb[2], 1);
        chk(st(2, 1) == 0, "R8 Invalid after writeback", st(2, 1), 0);
        issue(0, 2'b00, 1, 8'h00, 1, 8'h77, "R8 memory holds evicted word");

        // R10 read hit
        issue(0, 2'b00, 1, 8'h00, 1, 8'h77, "R10 read hit data");
        chk(last_cmd[0] == 2'b00, "R10 no bus", last_cmd[0], 0);
        chk(done_cyc[0] == start_cyc[0], "R10 read hit latency",
            done_cyc[0] - start_cyc[0], 0);

        // R11 local hit collides with snoop on same line
        fork
            issue(0, 2'b01, 1, 8'h11, 0, 8'h00, "R11 writer");
            issue(1, 2'b00, 1, 8'h00, 1, 8'h77, "R11 reader gets old word");
        join
        chk(done_cyc[0] == done_cyc[1] + 1, "R11 writer one cycle later",
            done_cyc[0] - done_cyc[1], 1);
        chk(last_cmd[0] == 2'b11, "R11 writer upgrades", last_cmd[0], 3);
        chk(st(0, 1) == 3 && st(1, 1) == 0, "R11 final states", st(1, 1), 0);

        // R9 four simultaneous bus requests
        fork
            issue(0, 2'b00, 2, 8'h00, 1, 8'h00, "R9 core0");
            issue(1, 2'b00, 3, 8'h00, 1, 8'h00, "R9 core1");
            issue(2, 2'b01, 0, 8'h42, 0, 8'h00, "R9 core2");
            issue(3, 2'b00, 1, 8'h00, 1, 8'h11, "R9 core3");
        join
        begin
            int mn, mx;
            bit distinct;
            mn = done_cyc[0]; mx = done_cyc[0]; distinct = 1;
            for (int a = 0; a < NC; a++) begin
                if (done_cyc[a] < mn) mn = done_cyc[a];
                if (done_cyc[a] > mx) mx = done_cyc[a];
                for (int b = a + 1; b < NC; b++)
                    if (done_cyc[a] == done_cyc[b]) distinct = 0;
            end
            chk(distinct, "R9 one grant per cycle", 0, 1);
            chk(mx - mn == 3, "R9 four consecutive grants", mx - mn, 3);
        end
        chk(st(2, 0) == 3 && st(3, 0) == 0, "R6 upgrade under load", st(2, 0), 3);

        repeat (2) @(posedge clk);
        chk(exp_q.size() == 0, "R10 all completions seen", exp_q.size(), 0);
        finish_run();
    end
endmodule